// File: doc/BRIEF.md
# Successive-Approximation Bit-Decision Timing Engine

This block sequences one conversion of a 10-bit successive-approximation converter. A start pulse from the conversion sequencer launches it. It raises a one-cycle hold strobe for the track-and-hold. It then presents a trial code to the DAC and samples a one-bit comparator input at fixed decision points. When all bits are settled, it loads a two's-complement result and pulses done. The approximation register is then cleared, so the next conversion begins from zero.

Bit timing is not uniform. After the hold cycle, two settling cycles pass before the most significant bit is decided. The second bit has a two-cycle window. Each of the remaining eight bits takes one cycle. A whole conversion spans 14 clock cycles. The trial code is built in offset-binary form, and the result is that code with its top bit inverted. An input at the bias level therefore reads 000h, positive full scale reads 1FFh and negative full scale reads 200h. An abort input ends a conversion at once, without a result.

Top module: `sar_timing_engine`

## Requirements
- R1: When start is sampled high at a clock edge, and abort is low at that edge, hold is high for exactly the next cycle and busy is high from that cycle on.
- R2: In the hold cycle and the three cycles after it (conversion cycles 0 to 3), trial equals 200h: only bit 9 is set. The comparator is sampled for bit 9 at the edge that ends cycle 3.
- R3: Bit 8 is on trial in cycles 4 and 5 and is decided at the end of cycle 5. Bits 7 down to 0 are then each on trial for one cycle, bit n in cycle 13-n. While a bit is on trial, trial holds all previously decided bits plus that bit.
- R4: A comparator input of 1 at a decision edge keeps the bit under test, and 0 clears it. The result is the final offset-binary code with bit 9 inverted: input code 512 gives 000h, 1023 gives 1FFh and 0 gives 200h.
- R5: done is a single-cycle pulse in conversion cycle 14, which is 14 cycles after the hold cycle. result changes only in a cycle where done is high.
- R6: When done is high and afterwards while idle, busy is low and trial is 000h, because the approximation register has been cleared.
- R7: A start during a conversion restarts it from cycle 0 with a cleared register, and the interrupted conversion produces no done.
- R8: An abort clears the register and busy at the next edge. No done follows, and result keeps its previous value. Abort takes priority over start.
- R9: After reset, hold, busy, done, trial and result are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Conversion start pulse from the sequencer |
| abort | input | 1 | Ends the current conversion without a result |
| cmp_hi | input | 1 | Comparator output, 1 when the input is at or above the trial level |
| hold | output | 1 | Track-and-hold strobe, high in conversion cycle 0 |
| busy | output | 1 | Conversion in progress |
| trial | output | 10 | Offset-binary trial code to the DAC |
| result | output | 10 | Two's-complement conversion result |
| done | output | 1 | One-cycle pulse when result is loaded |

## Verification
The embedded assertions check on every cycle the local relations: a hold strobe after each accepted start, with a first trial of 200h; done lasting one cycle; result changing only with done; the cleared register and idle state at done; and no done after an abort. The non-uniform schedule itself can only be shown by the bench scenarios. These include the exact trial code in each of the 14 cycles, the cycle in which done lands, the two's-complement value for the bias and both full-scale inputs, and the absence of a stale done after a restart or an abort.

// File: rtl/sar_timing_engine.sv
module sar_timing_engine #(
  parameter int WIDTH      = 10,
  parameter int SETTLE_CYC = 2,
  parameter int MSB2_CYC   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             abort,
  input  logic             cmp_hi,
  output logic             hold,
  output logic             busy,
  output logic [WIDTH-1:0] trial,
  output logic [WIDTH-1:0] result,
  output logic             done
);
  localparam int DEC_MSB  = SETTLE_CYC + 1;
  localparam int DEC_MSB2 = DEC_MSB + MSB2_CYC;
  localparam int LAST     = DEC_MSB2 + WIDTH - 2;
  localparam int CW       = $clog2(LAST + 1);
  localparam logic [WIDTH-1:0] TOP = {1'b1, {(WIDTH-1){1'b0}}};

  logic [CW-1:0]    phase;
  logic [WIDTH-1:0] sar, mask, next_sar;
  logic             decide, last;
  int unsigned      pos;

  always_comb begin
    if (phase <= CW'(DEC_MSB))       pos = WIDTH - 1;
    else if (phase <= CW'(DEC_MSB2)) pos = WIDTH - 2;
    else                             pos = WIDTH - 2 + DEC_MSB2 - int'(phase);
  end

  assign mask     = {{(WIDTH-1){1'b0}}, 1'b1} << pos;
  assign decide   = busy && (phase == CW'(DEC_MSB) || phase >= CW'(DEC_MSB2));
  assign last     = decide && phase == CW'(LAST);
  assign next_sar = cmp_hi ? (sar | mask) : sar;
  assign trial    = busy ? (sar | mask) : '0;
  assign hold     = busy && phase == '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      phase  <= '0;
      sar    <= '0;
      result <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (abort) begin
        busy  <= 1'b0;
        phase <= '0;
        sar   <= '0;
      end else if (start) begin
        busy  <= 1'b1;
        phase <= '0;
        sar   <= '0;
      end else if (busy) begin
        if (last) begin
          busy   <= 1'b0;
          phase  <= '0;
          sar    <= '0;
          done   <= 1'b1;
          result <= next_sar ^ TOP;
        end else begin
          if (decide) sar <= next_sar;
          phase <= phase + 1'b1;
        end
      end
    end
  end

  p_hold_after_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !abort) |=> (hold && busy && trial == TOP));

  p_hold_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !start) |=> !hold);

  p_settle_trial_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !start && !abort) |=> (trial == TOP));

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_result_on_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> done);

  p_clear_at_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && trial == '0));

  p_abort_no_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!done && !busy && trial == '0));
endmodule

// File: tb/sar_timing_engine_tb.sv
module sar_timing_engine_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       abort = 1'b0;
  logic [9:0] target = '0;
  logic       cmp_hi;
  logic       hold, busy, done;
  logic [9:0] trial, result;
  int         n_chk = 0;
  int         n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign cmp_hi = (target >= trial);

  sar_timing_engine u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort), .cmp_hi(cmp_hi),
    .hold(hold), .busy(busy), .trial(trial), .result(result), .done(done)
  );

  localparam logic [19:0] VEC [8] = '{
    {10'h200, 10'h000}, {10'h3FF, 10'h1FF}, {10'h000, 10'h200},
    {10'h001, 10'h201}, {10'h3FE, 10'h1FE}, {10'h155, 10'h355},
    {10'h2AA, 10'h0AA}, {10'h2BC, 10'h0BC}
  };

  task automatic chk(input bit ok, input string req, input logic [9:0] act, input logic [9:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic kick();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic follow(input logic [9:0] v, input logic [9:0] exp_res);
    logic [9:0] acc = '0;
    chk(hold == 1'b1 && busy == 1'b1, "R1 hold/busy in cycle 0", {8'd0, hold, busy}, 10'h003);
    for (int k = 0; k <= 14; k++) begin
      if (k <= 13) begin
        int p = (k <= 3) ? 9 : (k <= 5) ? 8 : 13 - k;
        logic [9:0] m = 10'd1 << p;
        chk(trial == (acc | m), (k <= 3) ? "R2 trial code" : "R3 trial code", trial, acc | m);
        chk(done == 1'b0, "R5 no early done", {9'd0, done}, 10'd0);
        if (k == 1) chk(hold == 1'b0, "R1 single hold", {9'd0, hold}, 10'd0);
        if (k == 3 || k == 5 || k >= 6) acc = acc | (v & m);
        @(negedge clk);
      end else begin
        chk(done == 1'b1, "R5 done in cycle 14", {9'd0, done}, 10'd1);
        chk(result == exp_res, "R4 result coding", result, exp_res);
        chk(trial == 10'h000 && busy == 1'b0, "R6 register cleared", trial, 10'h000);
        @(negedge clk);
        chk(done == 1'b0, "R5 done single cycle", {9'd0, done}, 10'd0);
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 10'h001, 10'h000);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(hold == 1'b0 && busy == 1'b0 && done == 1'b0, "R9 reset flags", {7'd0, hold, busy, done}, 10'd0);
    chk(trial == 10'h000 && result == 10'h000, "R9 reset data", trial | result, 10'h000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(trial == 10'h000, "R6 idle trial", trial, 10'h000);

    for (int i = 0; i < 8; i++) begin
      target = VEC[i][19:10];
      kick();
      follow(VEC[i][19:10], VEC[i][9:0]);
      repeat (2) @(negedge clk);
    end

    // R7: restart in the middle of a conversion
    target = 10'h050;
    kick();
    repeat (5) @(negedge clk);
    target = 10'h3C0;
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(trial == 10'h200, "R7 restart trial", trial, 10'h200);
    follow(10'h3C0, 10'h1C0);

    // R8: abort ends a conversion, no done, result kept
    target = 10'h100;
    kick();
    repeat (7) @(negedge clk);
    abort = 1'b1;
    @(negedge clk) abort = 1'b0;
    chk(trial == 10'h000 && busy == 1'b0, "R8 abort clears", trial, 10'h000);
    begin
      bit seen = 1'b0;
      for (int k = 0; k < 20; k++) begin
        if (done) seen = 1'b1;
        @(negedge clk);
      end
      chk(seen == 1'b0, "R8 no done after abort", {9'd0, seen}, 10'd0);
    end
    chk(result == 10'h1C0, "R8 result kept", result, 10'h1C0);

    // R8: abort wins over a simultaneous start
    @(negedge clk) begin start = 1'b1; abort = 1'b1; end
    @(negedge clk) begin start = 1'b0; abort = 1'b0; end
    chk(busy == 1'b0 && hold == 1'b0, "R8 abort priority", {8'd0, busy, hold}, 10'd0);

    target = 10'h3FF;
    kick();
    follow(10'h3FF, 10'h1FF);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule